// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry Arithmetic Logic Unit

This block is a purely combinational integer ALU assembled from one-bit slices. Every slice can complement its first operand bit and its second operand bit. It then picks one of four values: the AND of the two bits, their OR, the full-adder sum, or a "less" input bit. The slices are chained through their carries. Subtraction, NOR and signed compare all come from the two complement controls together with the carry-in of the lowest slice; the datapath has no dedicated circuit for any of them.

A 4-bit operation code drives the unit:

- Bit 3 complements operand A in every slice.
- Bit 2 complements operand B in every slice and also becomes the carry into bit 0.
- Bits 1:0 pick the slice output path.

The top slice also exports its raw sum bit as a "set" signal and computes overflow. The set signal is routed back to the less input of bit 0, which gives set-on-less-than. The unit has no clock, no state and no handshake. The operands and the code are plain control-style inputs, and the outputs settle in the same cycle once the carry ripple completes.

Top module: `ripple_alu`

## Requirements
- R1: Code 4'b0000 gives result = a AND b.
- R2: Code 4'b0001 gives result = a OR b.
- R3: Code 4'b0010 gives result = (a + b) mod 2^32, and carry_out equals bit 32 of the unsigned 33-bit sum.
- R4: Code 4'b0110 gives result = (a - b) mod 2^32, computed as a + ~b + 1, and carry_out is 1 exactly when a >= b as unsigned numbers.
- R5: Code 4'b0111 gives a result whose bit 0 is bit 31 of (a - b) mod 2^32, with no correction for overflow, and whose bits 31:1 are all 0.
- R6: Code 4'b1100 gives result = NOT (a OR b).
- R7: zero is 1 exactly when all 32 result bits are 0.
- R8: For codes 4'b0010 and 4'b0110, overflow is 1 exactly when the signed two's-complement result does not fit in 32 bits.
- R9: Any other code value forces an all-zero result, and therefore zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| alu_code | input | 4 | Operation code: bit 3 complements A, bit 2 negates B, bits 1:0 select the path |
| result | output | 32 | Selected result word |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow, from the carries into and out of the top slice |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
Because the unit is combinational, the bound checker judges every settled input combination, on every cycle, against relations at the ports:

- the add and subtract results and their carries;
- the upper result bits of a compare being zero;
- NOR against the operands;
- signed overflow on add;
- the all-zero result for unsupported codes.

The exact compare bit and the AND and OR paths are left to the bench's scenarios. So are the zero flag over matching operands, and the boundary operands 0, 1, all-ones, 0x7FFFFFFF and 0x80000000. In those scenarios a compare across the signed boundary shows the uncorrected sign bit, and the add and subtract carries land at their extremes.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    PATH_AND  = 2'd0,
    PATH_OR   = 2'd1,
    PATH_SUM  = 2'd2,
    PATH_LESS = 2'd3
  } path_sel_e;

  typedef enum logic [CODE_W-1:0] {
    CODE_AND = 4'b0000,
    CODE_OR  = 4'b0001,
    CODE_ADD = 4'b0010,
    CODE_SUB = 4'b0110,
    CODE_SLT = 4'b0111,
    CODE_NOR = 4'b1100
  } alu_code_e;

  typedef struct packed {
    logic      inv_a;
    logic      neg_b;
    path_sel_e sel;
  } slice_ctrl_t;

  function automatic logic pick_path(path_sel_e sel, logic x, logic y,
                                     logic sum, logic less);
    logic r;
    unique case (sel)
      PATH_AND:  r = x & y;
      PATH_OR:   r = x | y;
      PATH_SUM:  r = sum;
      default:   r = less;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic cout
);
  always_comb begin
    sum  = x ^ y ^ cin;
    cout = (x & y) | (x & cin) | (y & cin);
  end
endmodule

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import ripple_alu_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output slice_ctrl_t       ctrl,
  output logic              legal
);
  always_comb begin
    ctrl.inv_a = code[3];
    ctrl.neg_b = code[2];
    ctrl.sel   = path_sel_e'(code[1:0]);
    unique case (code)
      CODE_AND, CODE_OR, CODE_ADD, CODE_SUB, CODE_SLT, CODE_NOR: legal = 1'b1;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import ripple_alu_pkg::*;
(
  input  logic        a_bit,
  input  logic        b_bit,
  input  slice_ctrl_t ctrl,
  input  logic        cin,
  input  logic        less,
  output logic        res,
  output logic        cout
);
  logic x, y, sum;

  always_comb begin
    x = ctrl.inv_a ? ~a_bit : a_bit;
    y = ctrl.neg_b ? ~b_bit : b_bit;
  end

  alu_full_adder u_fa (.x(x), .y(y), .cin(cin), .sum(sum), .cout(cout));

  always_comb res = pick_path(ctrl.sel, x, y, sum, less);
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import ripple_alu_pkg::*;
(
  input  logic        a_bit,
  input  logic        b_bit,
  input  slice_ctrl_t ctrl,
  input  logic        cin,
  input  logic        less,
  output logic        res,
  output logic        cout,
  output logic        set_out,
  output logic        ovf
);
  logic x, y, sum;

  always_comb begin
    x = ctrl.inv_a ? ~a_bit : a_bit;
    y = ctrl.neg_b ? ~b_bit : b_bit;
  end

  alu_full_adder u_fa (.x(x), .y(y), .cin(cin), .sum(sum), .cout(cout));

  always_comb begin
    res     = pick_path(ctrl.sel, x, y, sum, less);
    set_out = sum;
    ovf     = cin ^ cout;
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] word,
  output logic             is_zero
);
  localparam int HALF = WIDTH / 2;
  logic lo_any, hi_any;

  always_comb begin
    lo_any  = |word[HALF-1:0];
    hi_any  = |word[WIDTH-1:HALF];
    is_zero = ~(lo_any | hi_any);
  end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  a_in,
  input  logic [WIDTH-1:0]  b_in,
  input  logic [CODE_W-1:0] alu_code,
  output logic [WIDTH-1:0]  result,
  output logic              zero,
  output logic              overflow,
  output logic              carry_out
);
  localparam int TOP = WIDTH - 1;

  slice_ctrl_t      ctrl;
  logic             legal;
  logic             carry [WIDTH+1];
  logic [WIDTH-1:0] raw_res;
  logic             msb_set;

  alu_ctrl_decode u_dec (.code(alu_code), .ctrl(ctrl), .legal(legal));

  assign carry[0] = ctrl.neg_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == TOP) begin : g_msb
      alu_msb_slice u_slice (
        .a_bit(a_in[i]), .b_bit(b_in[i]), .ctrl(ctrl),
        .cin(carry[i]), .less(1'b0),
        .res(raw_res[i]), .cout(carry[i+1]),
        .set_out(msb_set), .ovf(overflow)
      );
    end else if (i == 0) begin : g_lsb
      alu_slice u_slice (
        .a_bit(a_in[i]), .b_bit(b_in[i]), .ctrl(ctrl),
        .cin(carry[i]), .less(msb_set),
        .res(raw_res[i]), .cout(carry[i+1])
      );
    end else begin : g_mid
      alu_slice u_slice (
        .a_bit(a_in[i]), .b_bit(b_in[i]), .ctrl(ctrl),
        .cin(carry[i]), .less(1'b0),
        .res(raw_res[i]), .cout(carry[i+1])
      );
    end
  end

  assign carry_out = carry[WIDTH];
  assign result    = legal ? raw_res : '0;

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (.word(result), .is_zero(zero));
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0]  a_in,
  input logic [WIDTH-1:0]  b_in,
  input logic [CODE_W-1:0] alu_code,
  input logic [WIDTH-1:0]  result,
  input logic              zero,
  input logic              overflow,
  input logic              carry_out
);
  always_comb begin
    if (alu_code == CODE_ADD) begin
      // R3
      add_sum_chk: assert ({carry_out, result} == {1'b0, a_in} + {1'b0, b_in});
      // R8
      add_ovf_chk: assert (overflow ==
        ((a_in[WIDTH-1] == b_in[WIDTH-1]) && (result[WIDTH-1] != a_in[WIDTH-1])));
    end
    if (alu_code == CODE_SUB) begin
      // R4
      sub_diff_chk: assert (result == a_in - b_in && carry_out == (a_in >= b_in));
    end
    if (alu_code == CODE_SLT) begin
      // R5
      slt_upper_chk: assert (result[WIDTH-1:1] == '0);
    end
    if (alu_code == CODE_NOR) begin
      // R6
      nor_word_chk: assert (result == ~(a_in | b_in));
    end
    if (!(alu_code inside {CODE_AND, CODE_OR, CODE_ADD, CODE_SUB, CODE_SLT, CODE_NOR})) begin
      // R9
      bad_code_chk: assert (result == '0 && zero);
    end
  end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .alu_code(alu_code), .result(result),
  .zero(zero), .overflow(overflow), .carry_out(carry_out)
);

// File: tb/ripple_alu_test.sv
module ripple_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic [3:0]  alu_code = '0;
  logic [31:0] result;
  logic        zero, overflow, carry_out;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  ripple_alu uut (.a_in(a_in), .b_in(b_in), .alu_code(alu_code),
                  .result(result), .zero(zero), .overflow(overflow),
                  .carry_out(carry_out));

  task automatic expect_eq(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (a=%h b=%h code=%b)",
               tag, what, act, exp, a_in, b_in, alu_code);
    end
  endtask

  task automatic run_vec(logic [31:0] a, logic [31:0] b, logic [3:0] code);
    longint ua, ub, aa, bb, full, diff;
    logic [31:0] exp_res;
    logic exp_c, exp_v;
    string tag;
    ua = longint'(a); ub = longint'(b);
    aa = code[3] ? (ua ^ 64'hFFFF_FFFF) : ua;
    bb = code[2] ? (ub ^ 64'hFFFF_FFFF) : ub;
    full = aa + bb + (code[2] ? 1 : 0);
    exp_c = full[32];
    exp_v = (aa[31] == bb[31]) && (full[31] != aa[31]);
    diff = (ua - ub) & 64'hFFFF_FFFF;
    case (code)
      4'b0000: begin exp_res = a & b;           tag = "R1"; end
      4'b0001: begin exp_res = a | b;           tag = "R2"; end
      4'b0010: begin exp_res = 32'(ua + ub);    tag = "R3"; end
      4'b0110: begin exp_res = 32'(diff);       tag = "R4"; end
      4'b0111: begin exp_res = {31'd0, diff[31]}; tag = "R5"; end
      4'b1100: begin exp_res = ~(a | b);        tag = "R6"; end
      default: begin exp_res = '0;              tag = "R9"; end
    endcase
    @(negedge clk);
    a_in = a; b_in = b; alu_code = code;
    @(posedge clk);
    #1;
    expect_eq(tag, "result", longint'(result), longint'(exp_res));
    expect_eq("R7", "zero", longint'(zero), longint'(exp_res == 0));
    if (code == 4'b0010) begin
      expect_eq("R3", "carry_out", longint'(carry_out), longint'(exp_c));
      expect_eq("R8", "overflow", longint'(overflow), longint'(exp_v));
    end
    if (code == 4'b0110) begin
      expect_eq("R4", "carry_out", longint'(carry_out), longint'(ua >= ub));
      expect_eq("R8", "overflow", longint'(overflow), longint'(exp_v));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] corner [5];
    logic [3:0]  codes [6];
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000;
    codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0010;
    codes[3] = 4'b0110; codes[4] = 4'b0111; codes[5] = 4'b1100;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // reset state: zero operands with the AND code (R1, R7)
    expect_eq("R1", "reset result", longint'(result), 0);
    expect_eq("R7", "reset zero", longint'(zero), 1);

    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int k = 0; k < 6; k++)
          run_vec(corner[i], corner[j], codes[k]);

    // equal operands: subtract gives zero, compare gives 0 (R4, R5, R7)
    run_vec(32'h1234_5678, 32'h1234_5678, 4'b0110);
    run_vec(32'h1234_5678, 32'h1234_5678, 4'b0111);
    // signed boundary compare without overflow correction (R5)
    run_vec(32'h8000_0000, 32'h0000_0001, 4'b0111);
    run_vec(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);

    for (int n = 0; n < 300; n++)
      for (int k = 0; k < 6; k++)
        run_vec($urandom, $urandom, codes[k]);

    // unsupported codes (R9)
    for (int c = 0; c < 16; c++)
      if (!(c inside {0, 1, 2, 6, 7, 12}))
        for (int n = 0; n < 4; n++)
          run_vec($urandom, $urandom, 4'(c));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule